// File: doc/BRIEF.md
# Three-Level Transfer Request Arbiter

This block picks one winner per clock among the requesters that share on-chip memory and peripheral resources. Requester 0 is the cache-side memory controller, which carries the CPU's data and program fetches. Requesters 1 to 16 are the DMA channels, and requester 17 is the host port. The memory controller always asks at the urgent level. Each DMA channel and the host port sends a 3-bit priority code with its request. The valid codes are high and low; any other code is reported as an error, and that request is never served.

The winner is registered and is visible for one cycle as a one-hot grant vector, a requester ID and the level it won at. A requester holds its request until it sees its grant, then drops it. When several requesters ask at the same level, the turn rotates round-robin. The rotation starts just after the last requester that won at that level.

A configuration input settles contention for one memory bank between the CPU and the DMA engine. Set to 1, it holds back the memory controller while any valid DMA channel request targets the CPU's bank. The DMA channels go first, and the CPU goes after them. Cleared to 0, the CPU keeps its urgent precedence.

Top module: `xfer_prio_arb`

## Requirements
- R1: While reset is asserted, and until the first request after its release, `gnt`, `gnt_valid` and `err` are all zero.
- R2: At most one grant bit is set in any cycle. `gnt_valid` is 1 exactly when one bit is set, and that bit's index equals `gnt_id`.
- R3: Levels are served strictly in order: memory controller (urgent, level 0), then code 001 (high, level 1), then code 010 (low, level 2).
- R4: IDs are 0 for the memory controller, 1 to 16 for DMA channels 0 to 15, and 17 for the host port. `gnt_lvl` is 0 for urgent, 1 for high and 2 for low. The code of requester k (k from 1 to 17) sits in `prio[3k-1:3k-3]`.
- R5: When DMA or host requester k asks with code 000 or with a code from 011 to 111, `err[k]` is 1 in the cycle after the request is sampled. That requester is never granted. `err[0]` is always 0.
- R6: Within level 1, and likewise within level 2, the search for the next winner starts at the ID after the last one granted at that level and wraps from 17 to 0. Both pointers start so that the first search begins at ID 0.
- R7: A grant lasts one cycle. The requester granted in a cycle is not eligible in that same cycle, so a request that stays high is granted at most every other cycle.
- R8: With `cfg_dma_first` = 1, the memory controller request is held back while any DMA channel asks with a valid code and its bank (`dma_bank[4c+3:4c]` for channel c, with the default 4-bit bank field) equals `cpu_bank`.
- R9: With `cfg_dma_first` = 0, or with no DMA channel on the CPU's bank, a memory controller request is granted ahead of every other request.
- R10: A request sampled at a rising edge is granted, if it wins, in the cycle that starts at that edge. The synchronised reset lets go two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dma_first | input | 1 | 1: DMA channels go before the CPU on a shared bank |
| cpu_bank | input | 4 | Bank targeted by the memory controller request |
| dma_bank | input | 64 | Bank targeted by each DMA channel, 4 bits per channel |
| req | input | 18 | Request per requester, held until granted |
| prio | input | 51 | 3-bit priority code for requesters 1 to 17 |
| gnt | output | 18 | One-hot grant, one cycle long |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_id | output | 5 | ID of the granted requester |
| gnt_lvl | output | 2 | Level at which the grant was won |
| err | output | 18 | Requester asked with an invalid code |

## Verification
The grant outputs and the error flags are registered. Each is due in the cycle that begins at the rising edge where the request was sampled. After reset, two more edges pass before the first grant can appear. The bench drives its inputs on the falling edge and lets a behavioural model work out the next grant at the rising edge. It compares every output on the following falling edge, half a period after the edge on which the outputs were registered. A granted requester drops its request at that same falling edge, and the model sees the drop on the next rising edge, just as the design does.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_HIGH = 3'b001;
  localparam logic [CODE_W-1:0] CODE_LOW  = 3'b010;

  typedef enum logic [1:0] {
    LVL_URGENT = 2'd0,
    LVL_HIGH   = 2'd1,
    LVL_LOW    = 2'd2
  } lvl_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/arb_code_check.sv
module arb_code_check
  import arb_pkg::*;
#(
  parameter int NREQ = 18
) (
  input  logic [(NREQ-1)*CODE_W-1:0] prio,
  output logic [NREQ-1:0]            is_high,
  output logic [NREQ-1:0]            is_low,
  output logic [NREQ-1:0]            is_bad
);
  // Requester 0 has a fixed urgent level and no code.
  assign is_high[0] = 1'b0;
  assign is_low[0]  = 1'b0;
  assign is_bad[0]  = 1'b0;

  for (genvar k = 1; k < NREQ; k++) begin : g_code
    logic [CODE_W-1:0] code;
    assign code       = prio[(k-1)*CODE_W +: CODE_W];
    assign is_high[k] = (code == CODE_HIGH);
    assign is_low[k]  = (code == CODE_LOW);
    assign is_bad[k]  = !((code == CODE_HIGH) || (code == CODE_LOW));
  end
endmodule

// File: rtl/arb_bank_clash.sv
module arb_bank_clash #(
  parameter int NDMA   = 16,
  parameter int BANK_W = 4
) (
  input  logic [BANK_W-1:0]      cpu_bank,
  input  logic [NDMA*BANK_W-1:0] dma_bank,
  input  logic [NDMA-1:0]        dma_live,
  output logic                   clash
);
  logic [NDMA-1:0] hit;

  for (genvar c = 0; c < NDMA; c++) begin : g_hit
    assign hit[c] = dma_live[c] && (dma_bank[c*BANK_W +: BANK_W] == cpu_bank);
  end

  assign clash = |hit;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 18,
  parameter int IW = 5
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/xfer_prio_arb.sv
module xfer_prio_arb
  import arb_pkg::*;
#(
  parameter int NDMA   = 16,
  parameter int BANK_W = 4,
  localparam int NREQ  = NDMA + 2,
  localparam int IDW   = $clog2(NREQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_dma_first,
  input  logic [BANK_W-1:0]         cpu_bank,
  input  logic [NDMA*BANK_W-1:0]    dma_bank,
  input  logic [NREQ-1:0]           req,
  input  logic [(NREQ-1)*CODE_W-1:0] prio,
  output logic [NREQ-1:0]           gnt,
  output logic                      gnt_valid,
  output logic [IDW-1:0]            gnt_id,
  output logic [1:0]                gnt_lvl,
  output logic [NREQ-1:0]           err
);
  localparam logic [IDW-1:0] LAST_ID = IDW'(NREQ - 1);

  logic rst_q_n;

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  logic [NREQ-1:0] is_high, is_low, is_bad;

  arb_code_check #(.NREQ(NREQ)) u_code (
    .prio    (prio),
    .is_high (is_high),
    .is_low  (is_low),
    .is_bad  (is_bad)
  );

  // Registered state
  logic [NREQ-1:0] gnt_q, gnt_d;
  logic            vld_q, vld_d;
  logic [IDW-1:0]  id_q, id_d;
  lvl_e            lvl_q, lvl_d;
  logic [NREQ-1:0] err_q, err_d;
  logic [IDW-1:0]  last_hi_q, last_lo_q;
  logic            adv_hi, adv_lo;

  // The requester granted this cycle still holds its request; mask it.
  logic [NREQ-1:0] elig, live_hi, live_lo;
  assign elig    = req & ~gnt_q;
  assign live_hi = elig & is_high;
  assign live_lo = elig & is_low;

  logic [NDMA-1:0] dma_live;
  assign dma_live = live_hi[NDMA:1] | live_lo[NDMA:1];

  logic clash;

  arb_bank_clash #(.NDMA(NDMA), .BANK_W(BANK_W)) u_clash (
    .cpu_bank (cpu_bank),
    .dma_bank (dma_bank),
    .dma_live (dma_live),
    .clash    (clash)
  );

  logic cpu_go;
  assign cpu_go = elig[0] && !(cfg_dma_first && clash);

  logic           hi_found, lo_found;
  logic [IDW-1:0] hi_pick, lo_pick;

  arb_rr_pick #(.N(NREQ), .IW(IDW)) u_rr_hi (
    .cand  (live_hi),
    .last  (last_hi_q),
    .found (hi_found),
    .pick  (hi_pick)
  );

  arb_rr_pick #(.N(NREQ), .IW(IDW)) u_rr_lo (
    .cand  (live_lo),
    .last  (last_lo_q),
    .found (lo_found),
    .pick  (lo_pick)
  );

  // Next-state
  always_comb begin
    gnt_d  = '0;
    vld_d  = 1'b0;
    id_d   = '0;
    lvl_d  = LVL_URGENT;
    adv_hi = 1'b0;
    adv_lo = 1'b0;
    if (cpu_go) begin
      vld_d    = 1'b1;
      gnt_d[0] = 1'b1;
    end else if (hi_found) begin
      vld_d  = 1'b1;
      id_d   = hi_pick;
      lvl_d  = LVL_HIGH;
      gnt_d  = NREQ'(1) << hi_pick;
      adv_hi = 1'b1;
    end else if (lo_found) begin
      vld_d  = 1'b1;
      id_d   = lo_pick;
      lvl_d  = LVL_LOW;
      gnt_d  = NREQ'(1) << lo_pick;
      adv_lo = 1'b1;
    end
    err_d = req & is_bad;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      gnt_q <= '0;
      vld_q <= 1'b0;
      id_q  <= '0;
      lvl_q <= LVL_URGENT;
      err_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      vld_q <= vld_d;
      id_q  <= id_d;
      lvl_q <= lvl_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      last_hi_q <= LAST_ID;
    end else if (adv_hi) begin
      last_hi_q <= hi_pick;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      last_lo_q <= LAST_ID;
    end else if (adv_lo) begin
      last_lo_q <= lo_pick;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = vld_q;
  assign gnt_id    = id_q;
  assign gnt_lvl   = lvl_q;
  assign err       = err_q;
endmodule

// File: rtl/xfer_prio_arb_chk.sv
module xfer_prio_arb_chk #(
  parameter int NREQ = 18,
  parameter int IDW  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREQ-1:0]      req,
  input logic [(NREQ-1)*3-1:0] prio,
  input logic [NREQ-1:0]      gnt,
  input logic                 gnt_valid,
  input logic [IDW-1:0]       gnt_id,
  input logic [1:0]           gnt_lvl,
  input logic [NREQ-1:0]      err
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (gnt_valid == ($countones(gnt) == 1)));

  a_r2_id_match: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt[gnt_id]);

  a_r4_cpu_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |-> (gnt_lvl == 2'd0));

  a_r4_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_lvl != 2'd3));

  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !err[0]);

  for (genvar i = 0; i < NREQ; i++) begin : g_per
    a_r10_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> $past(req[i]));

    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |=> !gnt[i]);
  end

  for (genvar i = 1; i < NREQ; i++) begin : g_code
    a_r5_no_bad_grant: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> ($past(prio[(i-1)*3 +: 3]) == 3'b001 || $past(prio[(i-1)*3 +: 3]) == 3'b010));

    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err[i] |-> ($past(req[i]) && $past(prio[(i-1)*3 +: 3]) != 3'b001
                  && $past(prio[(i-1)*3 +: 3]) != 3'b010));
  end
endmodule

bind xfer_prio_arb xfer_prio_arb_chk #(.NREQ(NREQ), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .prio      (prio),
  .gnt       (gnt),
  .gnt_valid (gnt_valid),
  .gnt_id    (gnt_id),
  .gnt_lvl   (gnt_lvl),
  .err       (err)
);

// File: tb/xfer_prio_arb_test.sv
`timescale 1ns/1ps
module xfer_prio_arb_test;
  localparam int NDMA = 16;
  localparam int BW   = 4;
  localparam int NREQ = NDMA + 2;

  logic                   clk;
  logic                   rst_n;
  logic                   cfg_dma_first;
  logic [BW-1:0]          cpu_bank;
  logic [NDMA*BW-1:0]     dma_bank;
  logic [NREQ-1:0]        req;
  logic [(NREQ-1)*3-1:0]  prio;
  logic [NREQ-1:0]        gnt;
  logic                   gnt_valid;
  logic [4:0]             gnt_id;
  logic [1:0]             gnt_lvl;
  logic [NREQ-1:0]        err;

  xfer_prio_arb #(.NDMA(NDMA), .BANK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_dma_first(cfg_dma_first),
    .cpu_bank(cpu_bank), .dma_bank(dma_bank), .req(req), .prio(prio),
    .gnt(gnt), .gnt_valid(gnt_valid), .gnt_id(gnt_id), .gnt_lvl(gnt_lvl),
    .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk;
  int    n_bad;
  string cur;
  bit    auto_drop;
  bit    done;

  // Behavioural reference: expected outputs after each rising edge.
  bit              m_valid;
  int              m_id;
  int              m_lvl;
  bit [NREQ-1:0]   m_err;
  int              lastp [3];

  function automatic int code_of(int k);
    return int'(prio[(k-1)*3 +: 3]);
  endfunction

  function automatic bit ok_code(int c);
    return (c == 1) || (c == 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_id = 0; m_lvl = 0; m_err = '0;
      lastp[1] = NREQ - 1; lastp[2] = NREQ - 1;
    end else begin
      bit [NREQ-1:0] el;
      bit defer, nv;
      int nid, nl;
      for (int i = 0; i < NREQ; i++) el[i] = req[i] && !(m_valid && m_id == i);
      defer = 0;
      if (cfg_dma_first && el[0])
        for (int d = 1; d <= NDMA; d++)
          if (el[d] && ok_code(code_of(d)) && dma_bank[(d-1)*BW +: BW] == cpu_bank) defer = 1;
      nv = 0; nid = 0; nl = 0;
      if (el[0] && !defer) begin
        nv = 1;
      end else begin
        for (int lv = 1; lv <= 2; lv++)
          for (int k = 1; k <= NREQ; k++) begin
            int idx;
            idx = (lastp[lv] + k) % NREQ;
            if (!nv && idx != 0 && el[idx] && code_of(idx) == lv) begin
              nv = 1; nid = idx; nl = lv; lastp[lv] = idx;
            end
          end
      end
      m_valid = nv; m_id = nid; m_lvl = nl;
      for (int i = 0; i < NREQ; i++) m_err[i] = (i > 0) && req[i] && !ok_code(code_of(i));
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit [NREQ-1:0] exp_g;
    @(posedge clk);
    @(negedge clk);
    exp_g = m_valid ? (NREQ'(1) << m_id) : '0;
    chk(gnt_valid == m_valid, cur, "gnt_valid", gnt_valid, m_valid);
    if (m_valid) begin
      chk(gnt_id == 5'(m_id), cur, "gnt_id", gnt_id, m_id);
      chk(gnt_lvl == 2'(m_lvl), cur, "gnt_lvl", gnt_lvl, m_lvl);
    end
    chk(gnt == exp_g, "R2", "gnt vector", gnt, exp_g);
    chk(err == m_err, (cur == "R1") ? "R1" : "R5", "err", err, m_err);
    if (auto_drop) req = req & ~gnt;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ask(int k, logic [2:0] c);
    if (k > 0) prio[(k-1)*3 +: 3] = c;
    req[k] = 1'b1;
  endtask

  task automatic set_bank(int ch, logic [BW-1:0] b);
    dma_bank[ch*BW +: BW] = b;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0; auto_drop = 1;
    cur = "R1";
    rst_n = 0; cfg_dma_first = 0; cpu_bank = '0; dma_bank = '0;
    req = '0; prio = '0;
    run(3);
    rst_n = 1;
    run(4);

    cur = "R10";                 // single low request, one-cycle latency
    ask(3, 3'b010);
    run(3);

    cur = "R3";                  // urgent, then high, then low
    ask(0, 3'b000); ask(5, 3'b010); ask(17, 3'b001);
    run(5);

    cur = "R4";                  // host and last DMA channel IDs and levels
    ask(17, 3'b010); ask(16, 3'b001);
    run(4);

    cur = "R6";                  // rotation inside one level
    ask(2, 3'b001); ask(4, 3'b001); ask(9, 3'b001);
    run(5);
    ask(2, 3'b001); ask(4, 3'b001); ask(9, 3'b001); ask(11, 3'b001);
    run(6);
    ask(1, 3'b010); ask(8, 3'b010); ask(15, 3'b010);
    run(5);

    cur = "R5";                  // urgent and reserved codes from DMA/host
    ask(6, 3'b000); ask(7, 3'b111); ask(8, 3'b011); ask(17, 3'b101); ask(10, 3'b010);
    run(4);
    req[6] = 0; req[7] = 0; req[8] = 0; req[17] = 0;
    run(3);

    cur = "R7";                  // request held high after grant
    auto_drop = 0;
    ask(12, 3'b001);
    run(5);
    req = '0;
    auto_drop = 1;
    run(2);

    cur = "R8";                  // DMA first on shared bank
    cfg_dma_first = 1; cpu_bank = 4'd2; set_bank(4, 4'd2);
    ask(0, 3'b000); ask(5, 3'b010);
    run(4);
    ask(0, 3'b000); ask(5, 3'b001); ask(13, 3'b010); set_bank(12, 4'd2);
    run(5);

    cur = "R9";                  // different bank, then P cleared
    set_bank(4, 4'd1);
    ask(0, 3'b000); ask(5, 3'b010);
    run(4);
    cfg_dma_first = 0; set_bank(4, 4'd2);
    ask(0, 3'b000); ask(5, 3'b001);
    run(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule